// File: doc/BRIEF.md
# Boundary-Scan Identification Pinout Finder

This block looks for a boundary-scan test port hidden somewhere on a bank of general-purpose channels. After a start strobe it runs one trial for every ordered choice of three different channels, one each for the test clock, the mode-select line and the serial data output of the unknown target. In each trial it puts the target's test-port controller into its reset state, walks it into the data-register shift state, and clocks out 32 bits. Because the identification register is selected after a controller reset, these bits are the device identification word when the guess is right. The data input line of the target is never used.

A word that looks real is sent out on a valid/ready result port together with the three channel numbers. A word that does not look real is discarded. While a result waits to be accepted the sweep stops and the pins hold their levels. When the last trial is done the block gives a one-cycle done pulse. The test clock comes from a programmable divider of the system clock. A higher-level controller runs the block: it sets the channel count and the divider, pulses start, drains the results and waits for done.

Top module: `idscan_top`

## Requirements
- R1: After reset, and from the cycle after every done pulse until the next sweep, all channel output-enables are low, res_valid is low and done is low.
- R2: Only channels with an index below the channel count latched at start are used, and every channel is one of the three roles or none. Trials visit every ordered triple of distinct channels, with the clock channel as the outermost loop, the mode-select channel as the middle loop and the data-output channel as the innermost loop, each in ascending order. Results come out in that order.
- R3: During a sweep, the data-output channel of the current trial is not driven, and channels at or above the count are not driven. Every other used channel except the clock and mode-select channels is driven high.
- R4: The test clock has a half period of tck_div+2 system clocks. Each trial makes 41 rising clock edges. The mode-select line is high for the first five, then takes the values 0, 1, 0, 0, then stays low for the last 32. The data line is sampled at each of those 32 edges, and the first sample becomes bit 0 of the word.
- R5: The mode-select level changes only while the test clock is low.
- R6: A captured word equal to 0xFFFFFFFF, or with bit 0 equal to 0, is never reported. Any other word is reported as a result.
- R7: While res_valid is high and res_ready is low, res_valid stays high, all result fields and all pin levels are held, and the clock channel is held low.
- R8: done is a single-cycle pulse, one per sweep, after the last trial and after its result (if any) has been accepted. A start with a channel count below 3 runs no trial and pulses done within a few cycles.
- R9: A start strobe during a sweep is ignored. The sweep in progress continues, no result is repeated, and only one done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle strobe that begins a sweep when idle |
| chan_count | input | CNTW | Number of channels to search (clamped to NCH) |
| tck_div | input | DIVW | Test-clock half period is tck_div+2 system clocks |
| pin_in | input | NCH | Sampled level of each channel |
| pin_oe | output | NCH | Per-channel drive enable |
| pin_out | output | NCH | Per-channel drive level |
| res_valid | output | 1 | A candidate pinout is presented |
| res_ready | input | 1 | Consumer accepts the presented candidate |
| res_tck_ch | output | IW | Channel used as test clock |
| res_tms_ch | output | IW | Channel used as mode select |
| res_tdo_ch | output | IW | Channel read as data output |
| res_word | output | 32 | Captured identification word |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench models one or two targets, each with a full 16-state test-port controller, on random channels. Undriven channels read as pulled high, so a wrong guess reads back a constant word. The corner cases are:

- Identification words that are all ones or even. A filter that is wrong would report them.
- A target channel placed above the channel count. A range check that is wrong would find it anyway.
- Two targets. If the loop nesting is wrong, the results come out in the wrong order.
- A result held with ready low. A design that does not stall would move the pins or drop the word.
- A second start in the middle of a sweep. If it restarts, the result is reported twice.
- A channel count of two. If this case is wrong, the block would run trials or never signal done.

An off-by-one in the reset or navigation edges, or capture in the wrong bit order, shows up as a wrong word.

// File: rtl/idscan_pkg.sv
package idscan_pkg;

  localparam int WORD_W      = 32;
  localparam int RESET_EDGES = 5;
  localparam int NAV_EDGES   = 4;
  localparam int PRE_EDGES   = RESET_EDGES + NAV_EDGES;
  localparam int ALL_EDGES   = PRE_EDGES + WORD_W;
  localparam int EDGE_W      = $clog2(ALL_EDGES + 1);

  typedef enum logic [2:0] {
    SW_IDLE, SW_CHECK, SW_RUN, SW_HOLD, SW_NEXT, SW_END
  } sweep_state_t;

  typedef enum logic [1:0] {
    TQ_IDLE, TQ_LOW, TQ_HIGH
  } tseq_state_t;

  // Mode-select level presented before rising edge number e.
  function automatic logic tms_level(input logic [EDGE_W-1:0] e);
    if (e < EDGE_W'(RESET_EDGES))       return 1'b1;
    else if (e == EDGE_W'(RESET_EDGES + 1)) return 1'b1;
    else                                 return 1'b0;
  endfunction

  function automatic logic word_plausible(input logic [WORD_W-1:0] w);
    return w[0] && (w != {WORD_W{1'b1}});
  endfunction

endpackage

// File: rtl/idscan_clkdiv.sv
module idscan_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  localparam int CW = DIVW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = {1'b0, div} + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/idscan_tapseq.sv
module idscan_tapseq
  import idscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              tick,
  input  logic              tdo_in,
  output logic              run,
  output logic              tck,
  output logic              tms,
  output logic              fin,
  output logic [WORD_W-1:0] word
);
  tseq_state_t       st;
  logic [EDGE_W-1:0] edge_n;

  assign run = (st != TQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TQ_IDLE;
      edge_n <= '0;
      tck    <= 1'b0;
      tms    <= 1'b0;
      fin    <= 1'b0;
      word   <= '0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        TQ_IDLE: begin
          if (go) begin
            st     <= TQ_LOW;
            edge_n <= '0;
            tck    <= 1'b0;
            tms    <= tms_level('0);
            word   <= '0;
          end
        end
        TQ_LOW: begin
          if (tick) begin
            tck <= 1'b1;
            if (edge_n >= EDGE_W'(PRE_EDGES))
              word <= {tdo_in, word[WORD_W-1:1]};
            st <= TQ_HIGH;
          end
        end
        TQ_HIGH: begin
          if (tick) begin
            tck <= 1'b0;
            if (edge_n == EDGE_W'(ALL_EDGES - 1)) begin
              st  <= TQ_IDLE;
              fin <= 1'b1;
            end else begin
              edge_n <= edge_n + EDGE_W'(1);
              tms    <= tms_level(edge_n + EDGE_W'(1));
              st     <= TQ_LOW;
            end
          end
        end
        default: st <= TQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idscan_perm.sv
module idscan_perm #(
  parameter int IW   = 3,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic            step,
  input  logic [CNTW-1:0] count,
  output logic [IW-1:0]   ck_idx,
  output logic [IW-1:0]   ms_idx,
  output logic [IW-1:0]   do_idx,
  output logic            distinct,
  output logic            last
);
  logic [CNTW-1:0] top_idx;
  logic ck_top, ms_top, do_top;

  assign top_idx  = count - CNTW'(1);
  assign ck_top   = (CNTW'(ck_idx) == top_idx);
  assign ms_top   = (CNTW'(ms_idx) == top_idx);
  assign do_top   = (CNTW'(do_idx) == top_idx);
  assign last     = ck_top && ms_top && do_top;
  assign distinct = (ck_idx != ms_idx) && (ms_idx != do_idx) && (ck_idx != do_idx);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      ck_idx <= '0;
      ms_idx <= '0;
      do_idx <= '0;
    end else if (step) begin
      if (do_top) begin
        do_idx <= '0;
        if (ms_top) begin
          ms_idx <= '0;
          if (!ck_top) ck_idx <= ck_idx + IW'(1);
        end else begin
          ms_idx <= ms_idx + IW'(1);
        end
      end else begin
        do_idx <= do_idx + IW'(1);
      end
    end
  end
endmodule

// File: rtl/idscan_pins.sv
module idscan_pins #(
  parameter int NCH  = 8,
  parameter int IW   = 3,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic [CNTW-1:0] count,
  input  logic [IW-1:0]   ck_idx,
  input  logic [IW-1:0]   ms_idx,
  input  logic [IW-1:0]   do_idx,
  input  logic            tck,
  input  logic            tms,
  input  logic [NCH-1:0]  pin_in,
  output logic [NCH-1:0]  pin_oe,
  output logic [NCH-1:0]  pin_out,
  output logic            tdo_sync
);
  logic sync_a;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [CNTW-1:0] CPOS = CNTW'(c);
    localparam logic [IW-1:0]   CIDX = IW'(c);
    always_ff @(posedge clk) begin
      if (rst || !active || (CPOS >= count) || (CIDX == do_idx)) begin
        pin_oe[c]  <= 1'b0;
        pin_out[c] <= 1'b0;
      end else if (CIDX == ck_idx) begin
        pin_oe[c]  <= 1'b1;
        pin_out[c] <= tck;
      end else if (CIDX == ms_idx) begin
        pin_oe[c]  <= 1'b1;
        pin_out[c] <= tms;
      end else begin
        pin_oe[c]  <= 1'b1;
        pin_out[c] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a   <= 1'b1;
      tdo_sync <= 1'b1;
    end else begin
      sync_a   <= pin_in[do_idx];
      tdo_sync <= sync_a;
    end
  end
endmodule

// File: rtl/idscan_top.sv
module idscan_top
  import idscan_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DIVW = 8,
  parameter int IW   = $clog2(NCH),
  parameter int CNTW = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNTW-1:0]   chan_count,
  input  logic [DIVW-1:0]   tck_div,
  input  logic [NCH-1:0]    pin_in,
  output logic [NCH-1:0]    pin_oe,
  output logic [NCH-1:0]    pin_out,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [IW-1:0]     res_tck_ch,
  output logic [IW-1:0]     res_tms_ch,
  output logic [IW-1:0]     res_tdo_ch,
  output logic [WORD_W-1:0] res_word,
  output logic              done
);
  sweep_state_t    st;
  logic [CNTW-1:0] count_q;
  logic [IW-1:0]   ck_idx, ms_idx, do_idx;
  logic            distinct, last;
  logic            perm_init, perm_step;
  logic            go, seq_run, tick, fin;
  logic            tck_lvl, tms_lvl, tdo_sync;
  logic [WORD_W-1:0] cap_word;
  logic            too_few;

  assign too_few   = (chan_count < CNTW'(3));
  assign perm_init = (st == SW_IDLE) && start && !too_few;
  assign perm_step = ((st == SW_CHECK) && !distinct && !last) ||
                     ((st == SW_NEXT) && !last);

  idscan_perm #(.IW(IW), .CNTW(CNTW)) u_perm (
    .clk(clk), .rst(rst), .init(perm_init), .step(perm_step), .count(count_q),
    .ck_idx(ck_idx), .ms_idx(ms_idx), .do_idx(do_idx),
    .distinct(distinct), .last(last)
  );

  idscan_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .run(seq_run), .div(tck_div), .tick(tick)
  );

  idscan_tapseq u_seq (
    .clk(clk), .rst(rst), .go(go), .tick(tick), .tdo_in(tdo_sync),
    .run(seq_run), .tck(tck_lvl), .tms(tms_lvl), .fin(fin), .word(cap_word)
  );

  idscan_pins #(.NCH(NCH), .IW(IW), .CNTW(CNTW)) u_pins (
    .clk(clk), .rst(rst), .active(st != SW_IDLE), .count(count_q),
    .ck_idx(ck_idx), .ms_idx(ms_idx), .do_idx(do_idx),
    .tck(tck_lvl), .tms(tms_lvl), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .tdo_sync(tdo_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SW_IDLE;
      count_q    <= '0;
      go         <= 1'b0;
      done       <= 1'b0;
      res_valid  <= 1'b0;
      res_tck_ch <= '0;
      res_tms_ch <= '0;
      res_tdo_ch <= '0;
      res_word   <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      unique case (st)
        SW_IDLE: begin
          if (start) begin
            count_q <= (chan_count > CNTW'(NCH)) ? CNTW'(NCH) : chan_count;
            if (too_few) done <= 1'b1;
            else         st   <= SW_CHECK;
          end
        end
        SW_CHECK: begin
          if (distinct) begin
            go <= 1'b1;
            st <= SW_RUN;
          end else if (last) begin
            st <= SW_END;
          end
        end
        SW_RUN: begin
          if (fin) begin
            if (word_plausible(cap_word)) begin
              res_valid  <= 1'b1;
              res_tck_ch <= ck_idx;
              res_tms_ch <= ms_idx;
              res_tdo_ch <= do_idx;
              res_word   <= cap_word;
              st         <= SW_HOLD;
            end else begin
              st <= SW_NEXT;
            end
          end
        end
        SW_HOLD: begin
          if (res_ready) begin
            res_valid <= 1'b0;
            st        <= SW_NEXT;
          end
        end
        SW_NEXT: st <= last ? SW_END : SW_CHECK;
        SW_END: begin
          done <= 1'b1;
          st   <= SW_IDLE;
        end
        default: st <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idscan_chk.sv
module idscan_chk #(
  parameter int NCH = 8,
  parameter int IW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] pin_oe,
  input logic [NCH-1:0] pin_out,
  input logic           res_valid,
  input logic           res_ready,
  input logic [IW-1:0]  res_tck_ch,
  input logic [IW-1:0]  res_tms_ch,
  input logic [IW-1:0]  res_tdo_ch,
  input logic [31:0]    res_word,
  input logic           done,
  input logic           tck_lvl,
  input logic           tms_lvl
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> (pin_oe == '0) && !res_valid);

  assert_distinct_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_tck_ch != res_tms_ch) && (res_tms_ch != res_tdo_ch) &&
                  (res_tck_ch != res_tdo_ch));

  assert_tdo_free_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !pin_oe[res_tdo_ch] && pin_oe[res_tms_ch]);

  assert_half_period_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(tck_lvl) |=> $stable(tck_lvl));

  assert_tms_setup_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(tms_lvl) |-> !tck_lvl);

  assert_word_ok_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_word[0] && (res_word != 32'hFFFF_FFFF));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_word) &&
      $stable(res_tck_ch) && $stable(res_tms_ch) && $stable(res_tdo_ch) &&
      $stable(pin_out) && $stable(pin_oe));

  assert_stall_low_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> pin_oe[res_tck_ch] && !pin_out[res_tck_ch]);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_clear_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !res_valid);
endmodule

bind idscan_top idscan_chk #(.NCH(NCH), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .pin_oe(pin_oe), .pin_out(pin_out),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_tck_ch(res_tck_ch), .res_tms_ch(res_tms_ch), .res_tdo_ch(res_tdo_ch),
  .res_word(res_word), .done(done), .tck_lvl(tck_lvl), .tms_lvl(tms_lvl)
);

// File: tb/test_idscan_top.sv
`timescale 1ns/1ps

module tb_tap_model (
  input  logic        tck,
  input  logic        tms,
  input  logic [31:0] id,
  output logic        tdo
);
  typedef enum logic [3:0] {
    TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
    SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR
  } ts_t;
  ts_t st = TLR;
  logic [31:0] sh = 32'h0;

  assign tdo = (st == SHDR) ? sh[0] : 1'b1;

  always @(posedge tck) begin
    if (st == CDR) sh <= id;
    else if (st == SHDR) sh <= {1'b1, sh[31:1]};
    case (st)
      TLR:  st <= tms ? TLR  : RTI;
      RTI:  st <= tms ? SDR  : RTI;
      SDR:  st <= tms ? SIR  : CDR;
      CDR:  st <= tms ? E1DR : SHDR;
      SHDR: st <= tms ? E1DR : SHDR;
      E1DR: st <= tms ? UDR  : PDR;
      PDR:  st <= tms ? E2DR : PDR;
      E2DR: st <= tms ? UDR  : SHDR;
      UDR:  st <= tms ? SDR  : RTI;
      SIR:  st <= tms ? TLR  : CIR;
      CIR:  st <= tms ? E1IR : SHIR;
      SHIR: st <= tms ? E1IR : SHIR;
      E1IR: st <= tms ? UIR  : PIR;
      PIR:  st <= tms ? E2IR : PIR;
      E2IR: st <= tms ? UIR  : SHIR;
      default: st <= tms ? SDR : RTI;
    endcase
  end
endmodule

module test_idscan_top;
  localparam int NCH  = 8;
  localparam int DIVW = 8;
  localparam int IW   = $clog2(NCH);
  localparam int CNTW = $clog2(NCH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNTW-1:0] chan_count = '0;
  logic [DIVW-1:0] tck_div = '0;
  logic [NCH-1:0] pin_in;
  logic [NCH-1:0] pin_oe, pin_out;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [IW-1:0] res_tck_ch, res_tms_ch, res_tdo_ch;
  logic [31:0] res_word;
  logic done;

  always #2.5 clk = ~clk;

  idscan_top #(.NCH(NCH), .DIVW(DIVW)) i_idscan_top (
    .clk(clk), .rst(rst), .start(start), .chan_count(chan_count),
    .tck_div(tck_div), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_tck_ch(res_tck_ch), .res_tms_ch(res_tms_ch), .res_tdo_ch(res_tdo_ch),
    .res_word(res_word), .done(done)
  );

  // Target placement
  bit en1 = 1'b0, en2 = 1'b0;
  int t1 = 0, m1 = 1, d1 = 2, t2 = 3, m2 = 4, d2 = 5;
  logic [31:0] id1 = 32'h1, id2 = 32'h1;

  logic [NCH-1:0] line;
  logic tdo1, tdo2;
  assign line = (pin_oe & pin_out) | ~pin_oe;

  tb_tap_model u_t1 (.tck(en1 ? line[t1] : 1'b0), .tms(line[m1]), .id(id1), .tdo(tdo1));
  tb_tap_model u_t2 (.tck(en2 ? line[t2] : 1'b0), .tms(line[m2]), .id(id2), .tdo(tdo2));

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      pin_in[c] = 1'b1;
      if (en1 && d1 == c) pin_in[c] = tdo1;
      if (en2 && d2 == c) pin_in[c] = tdo2;
    end
  end

  int n_chk = 0, n_bad = 0;
  int got_n = 0, done_n = 0, pin_bad = 0, cur_cnt = 0;
  int got_t[16], got_m[16], got_d[16];
  logic [31:0] got_w[16];
  int exp_n;
  int exp_t[2], exp_m[2], exp_d[2];
  logic [31:0] exp_w[2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid && res_ready) begin
        if (got_n < 16) begin
          got_t[got_n] = int'(res_tck_ch);
          got_m[got_n] = int'(res_tms_ch);
          got_d[got_n] = int'(res_tdo_ch);
          got_w[got_n] = res_word;
        end
        got_n++;
      end
      if (done) done_n++;
      if (|pin_oe) begin
        int undrv, low;
        undrv = 0; low = 0;
        for (int c = 0; c < NCH; c++) begin
          if (c >= cur_cnt && pin_oe[c]) pin_bad++;
          if (c < cur_cnt && !pin_oe[c]) undrv++;
          if (pin_oe[c] && !pin_out[c]) low++;
        end
        if (undrv > 1 || low > 2) pin_bad++;
      end
    end
  end

  function automatic bit fits(int t, int m, int d, logic [31:0] w, int cnt);
    return t < cnt && m < cnt && d < cnt && w[0] && (w != 32'hFFFF_FFFF);
  endfunction

  task automatic build_expected(input int cnt);
    bit a, b;
    int ka, kb;
    a = en1 && fits(t1, m1, d1, id1, cnt);
    b = en2 && fits(t2, m2, d2, id2, cnt);
    ka = (t1 * NCH + m1) * NCH + d1;
    kb = (t2 * NCH + m2) * NCH + d2;
    exp_n = 0;
    if (a && (!b || ka < kb)) begin
      exp_t[exp_n] = t1; exp_m[exp_n] = m1; exp_d[exp_n] = d1; exp_w[exp_n] = id1; exp_n++;
    end
    if (b) begin
      exp_t[exp_n] = t2; exp_m[exp_n] = m2; exp_d[exp_n] = d2; exp_w[exp_n] = id2; exp_n++;
    end
    if (a && b && ka > kb) begin
      exp_t[exp_n] = t1; exp_m[exp_n] = m1; exp_d[exp_n] = d1; exp_w[exp_n] = id1; exp_n++;
    end
  endtask

  task automatic begin_sweep(input int cnt, input int div);
    @(negedge clk);
    chan_count = CNTW'(cnt);
    tck_div = DIVW'(div);
    cur_cnt = (cnt > NCH) ? NCH : cnt;
    got_n = 0; done_n = 0; pin_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_sweep(input int cnt, input string wtag);
    while (done_n == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    build_expected(cnt);
    chk(done_n == 1, "R8", 64'(done_n), 64'd1);
    chk(got_n == exp_n, "R2", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_t[i] == exp_t[i] && got_m[i] == exp_m[i] && got_d[i] == exp_d[i], "R2",
          64'((got_t[i] << 16) | (got_m[i] << 8) | got_d[i]),
          64'((exp_t[i] << 16) | (exp_m[i] << 8) | exp_d[i]));
      chk(got_w[i] == exp_w[i], wtag, 64'(got_w[i]), 64'(exp_w[i]));
    end
    chk(pin_bad == 0, "R3", 64'(pin_bad), 64'd0);
  endtask

  task automatic sweep(input int cnt, input int div, input string wtag);
    begin_sweep(cnt, div);
    finish_sweep(cnt, wtag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pin_oe == '0, "R1", 64'(pin_oe), 64'd0);
    chk(!res_valid && !done, "R1", 64'({res_valid, done}), 64'd0);

    // R8: too few channels
    en1 = 1'b1; t1 = 0; m1 = 1; d1 = 2; id1 = 32'h1234_5679;
    begin_sweep(2, 0);
    repeat (5) @(negedge clk);
    chk(done_n == 1, "R8", 64'(done_n), 64'd1);
    chk(got_n == 0, "R8", 64'(got_n), 64'd0);
    chk(pin_oe == '0, "R1", 64'(pin_oe), 64'd0);

    // Minimal sweep, target on the first triple (R4, R5)
    sweep(3, 0, "R4/R5");
    chk(pin_oe == '0 && !res_valid, "R1", 64'(pin_oe), 64'd0);

    // R6: all ones and even word rejected
    id1 = 32'hFFFF_FFFF; t1 = 2; m1 = 0; d1 = 3;
    sweep(4, 0, "R6");
    id1 = 32'h0BAD_CAFE;
    sweep(4, 1, "R6");

    // R2: target partly above the channel count
    id1 = 32'h4A5B_1003; t1 = 1; m1 = 4; d1 = 6;
    sweep(5, 0, "R2");

    // R2 ordering with two targets
    en2 = 1'b1;
    t1 = 3; m1 = 0; d1 = 1; id1 = 32'h7654_3211;
    t2 = 2; m2 = 4; d2 = 0; id2 = 32'h0C0F_FEE1;
    d2 = 4; m2 = 0; t2 = 2;
    t1 = 3; m1 = 1; d1 = 0;
    // disjoint channels: t2=2,m2=0,d2=4 and t1=3,m1=1,d1=... keep disjoint
    d1 = 1; m1 = 3; t1 = 1;
    t1 = 3; m1 = 1; d1 = 5;
    sweep(6, 0, "R4");
    en2 = 1'b0;

    // R7: backpressure
    t1 = 1; m1 = 0; d1 = 3; id1 = 32'h2E64_9013;
    res_ready = 1'b0;
    begin_sweep(4, 0);
    while (!res_valid) @(negedge clk);
    begin
      logic [31:0] w0;
      logic [NCH-1:0] po, pe;
      bit ok;
      w0 = res_word; po = pin_out; pe = pin_oe; ok = 1'b1;
      repeat (30) begin
        @(negedge clk);
        if (!res_valid || res_word != w0 || pin_out != po || pin_oe != pe) ok = 1'b0;
      end
      chk(ok, "R7", 64'(res_word), 64'(w0));
      chk(done_n == 0, "R7", 64'(done_n), 64'd0);
    end
    res_ready = 1'b1;
    finish_sweep(4, "R7");

    // R9: start during a sweep is ignored
    t1 = 0; m1 = 1; d1 = 2; id1 = 32'h0471_017F;
    begin_sweep(4, 0);
    repeat (400) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_sweep(4, "R9");
    repeat (300) @(negedge clk);
    chk(done_n == 1 && got_n == 1, "R9", 64'({done_n[15:0], got_n[15:0]}), 64'h10001);

    // Random sweeps
    for (int r = 0; r < 4; r++) begin
      int cnt;
      cnt = 4 + int'($urandom % 2);
      t1 = int'($urandom % cnt);
      do m1 = int'($urandom % cnt); while (m1 == t1);
      do d1 = int'($urandom % cnt); while (d1 == t1 || d1 == m1);
      id1 = $urandom | 32'h1;
      if (id1 == 32'hFFFF_FFFF) id1 = 32'h0000_0003;
      sweep(cnt, int'($urandom % 2), "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule